// File: doc/BRIEF.md
# Four-Channel DMA Trigger Scheduler

This block sits between a DMA controller's register file and its transfer engine. It decides when each of four channels holds work and which channel owns the engine. For each channel it stores an enable flag, a count of units left in the current block, and a short start-delay counter. A channel gets work in one of three ways:

- when it is armed in immediate mode;
- on a horizontal- or vertical-blank strobe;
- on an external FIFO request line (channels 1 and 2 only).

The engine moves one unit at a time on behalf of the granted channel. It reports each finished unit with a single-cycle `unit_done_i` pulse. After every unit the scheduler picks the owner again: the lowest-numbered channel that is ready wins. A unit already under way is always allowed to finish before ownership changes.

When the last unit of a block completes, the block-end actions run:

- The scheduler either clears the channel's enable or leaves it armed for its next trigger.
- If the destination mode asks for it, the scheduler tells the engine to restore the working destination.
- If the channel's interrupt enable is set, the scheduler raises that channel's interrupt.

While any enabled channel still has units left, a stall output holds the CPU off the bus.

Top module: `dma_trig_sched`

## Requirements
- R1: A channel armed with trigger mode 0 (immediate) while disabled is granted exactly 3 clocks after the arm edge: `grant_o` reads zero after the second clock edge following the arm edge, and shows that channel after the third.
- R2: A started block moves exactly as many units as `count_i` holds for that channel. A count of zero means 2^CW units.
- R3: Mode 1 starts on `vblank_i` and mode 2 starts on `hblank_i`. A strobe only starts an enabled channel that has no units left, and the grant follows 3 clocks later. A strobe that arrives while the channel is busy, or a strobe of the other kind, adds no units.
- R4: With mode 3 (special request), channel 1 starts on `fifo_req_i[0]` and channel 2 starts on `fifo_req_i[1]`. Channels 0 and 3 never start in mode 3, whatever the strobes do.
- R5: `grant_o` is one-hot or zero, with bit i standing for channel i. It names the lowest-numbered enabled channel that has units left and whose start delay has run out. The choice is made again after every unit, so a lower-numbered channel that becomes ready takes over between two units of a higher-numbered one.
- R6: While `grant_o` is nonzero and no `unit_done_i` arrives, `grant_o` keeps its value.
- R7: At block end the scheduler clears the channel's enable if repeat is off or the mode is immediate. Otherwise the enable stays set and the next matching trigger starts a new block. A channel that has been cleared ignores further strobes.
- R8: At block end, in the clock after the final `unit_done_i` edge, `done_o` pulses for one cycle on that channel's bit. `irq_o` pulses with it if the channel's irq enable is set. `dst_reload_o` pulses with it if the channel's destination control equals 3.
- R9: `stall_o` is high exactly while some enabled channel has units left. It falls in the cycle after the edge that completes the last such unit.
- R10: Reset clears all enables, counts, grants and pulses. An arm pulse to a channel that is already enabled is ignored and does not restart its block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 4 | Per-channel arm pulse from the register file |
| vblank_i | input | 1 | Vertical-blank strobe |
| hblank_i | input | 1 | Horizontal-blank strobe |
| fifo_req_i | input | 2 | FIFO requests: bit 0 serves channel 1, bit 1 serves channel 2 |
| mode_i | input | 8 | Trigger mode, 2 bits per channel (0 immediate, 1 vblank, 2 hblank, 3 special) |
| repeat_i | input | 4 | Per-channel repeat flag |
| irq_en_i | input | 4 | Per-channel interrupt enable |
| dst_ctl_i | input | 8 | Destination control, 2 bits per channel; 3 means reload at block end |
| count_i | input | 4*CW | Programmed unit count, CW bits per channel |
| unit_done_i | input | 1 | Engine finished one unit for the granted channel |
| grant_o | output | 4 | One-hot owner of the transfer engine |
| stall_o | output | 1 | CPU stall request |
| enable_o | output | 4 | Current enable flag of each channel |
| done_o | output | 4 | One-cycle block-end pulse per channel |
| irq_o | output | 4 | One-cycle interrupt pulse per channel |
| dst_reload_o | output | 4 | One-cycle destination-reload pulse per channel |

## Verification
Immediate starts on every channel are swept over every count value from 1 to 2^CW − 1, plus zero. This separates the start latency, the block length, the zero-count rule and the enable-clear rule. It also covers every combination of interrupt and reload flag.

Blank and FIFO strobes are applied to channels in each mode, including strobes that arrive while a block is running. These show which triggers start which channels, and whether a busy channel is retriggered. Channel pairs are armed either together or two cycles apart, which tells plain priority ordering apart from preemption between units. A slow engine, taking three cycles per unit, then shows that a unit in flight is never cut off and that a second arm to a running channel does not restart it.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  localparam int NUM_CH = 4;

  typedef enum logic [1:0] {
    TRIG_NOW     = 2'd0,
    TRIG_VBLANK  = 2'd1,
    TRIG_HBLANK  = 2'd2,
    TRIG_SPECIAL = 2'd3
  } trig_mode_e;

  localparam logic [1:0] DST_RELOAD = 2'd3;

  // Units in a block: a zero count stands for the full 2^cw range.
  function automatic logic [32:0] block_units(input logic [31:0] cnt, input int cw);
    return (cnt == 32'd0) ? (33'd1 << cw) : {1'b0, cnt};
  endfunction

endpackage

// File: rtl/dma_trig_chan.sv
module dma_trig_chan
  import dma_sched_pkg::*;
#(
  parameter int CH        = 0,
  parameter int CW        = 16,
  parameter int START_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          vblank_i,
  input  logic          hblank_i,
  input  logic          special_i,
  input  logic [1:0]    mode_i,
  input  logic          repeat_i,
  input  logic          irq_en_i,
  input  logic [1:0]    dst_ctl_i,
  input  logic [CW-1:0] count_i,
  input  logic          unit_done_i,
  output logic          en_o,
  output logic          pending_o,
  output logic          ready_next_o,
  output logic          done_o,
  output logic          irq_o,
  output logic          reload_o
);

  localparam int RW = CW + 1;
  localparam int WW = $clog2(START_LAT + 1);
  localparam logic [WW-1:0] WAIT_LOAD = START_LAT[WW-1:0];
  localparam bit SPECIAL_OK = (CH == 1) || (CH == 2);

  trig_mode_e    mode;
  logic          en_q, en_d;
  logic [RW-1:0] rem_q, rem_d;
  logic [WW-1:0] wait_q, wait_d;
  logic          start_now, strobe_hit, retrig, trig, last_unit;
  logic [32:0]   units_full;

  assign mode       = trig_mode_e'(mode_i);
  assign units_full = block_units({{(32-CW){1'b0}}, count_i}, CW);

  always_comb begin
    start_now  = (mode == TRIG_NOW) && arm_i && !en_q;
    strobe_hit = ((mode == TRIG_VBLANK) && vblank_i) ||
                 ((mode == TRIG_HBLANK) && hblank_i) ||
                 ((mode == TRIG_SPECIAL) && SPECIAL_OK && special_i);
    retrig     = en_q && (rem_q == '0) && strobe_hit;
    trig       = start_now || retrig;
    last_unit  = unit_done_i && (rem_q == RW'(1));

    en_d   = en_q;
    rem_d  = rem_q;
    wait_d = (wait_q != '0) ? wait_q - WW'(1) : '0;
    if (arm_i && !en_q) en_d = 1'b1;
    if (trig) begin
      rem_d  = units_full[RW-1:0];
      wait_d = WAIT_LOAD;
    end else if (unit_done_i && rem_q != '0) begin
      rem_d = rem_q - RW'(1);
      if (last_unit && (!repeat_i || mode == TRIG_NOW)) en_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rem_q    <= '0;
      wait_q   <= '0;
      done_o   <= 1'b0;
      irq_o    <= 1'b0;
      reload_o <= 1'b0;
    end else begin
      en_q     <= en_d;
      rem_q    <= rem_d;
      wait_q   <= wait_d;
      done_o   <= last_unit;
      irq_o    <= last_unit && irq_en_i;
      reload_o <= last_unit && (dst_ctl_i == DST_RELOAD);
    end
  end

  assign en_o         = en_q;
  assign pending_o    = en_q && (rem_q != '0);
  assign ready_next_o = en_d && (rem_d != '0) && (wait_d == '0);

endmodule

// File: rtl/dma_grant_arb.sv
module dma_grant_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ready_next_i,
  input  logic         unit_done_i,
  output logic [N-1:0] grant_o
);

  function automatic logic [N-1:0] lowest_set(input logic [N-1:0] v);
    return v & (~v + N'(1));
  endfunction

  logic [N-1:0] grant_q;
  logic         reselect;

  assign reselect = (grant_q == '0) || unit_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) grant_q <= '0;
    else if (reselect) grant_q <= lowest_set(ready_next_i);
  end

  assign grant_o = grant_q;

endmodule

// File: rtl/dma_trig_sched.sv
module dma_trig_sched
  import dma_sched_pkg::*;
#(
  parameter int CW        = 16,
  parameter int START_LAT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         arm_i,
  input  logic               vblank_i,
  input  logic               hblank_i,
  input  logic [1:0]         fifo_req_i,
  input  logic [7:0]         mode_i,
  input  logic [3:0]         repeat_i,
  input  logic [3:0]         irq_en_i,
  input  logic [7:0]         dst_ctl_i,
  input  logic [4*CW-1:0]    count_i,
  input  logic               unit_done_i,
  output logic [3:0]         grant_o,
  output logic               stall_o,
  output logic [3:0]         enable_o,
  output logic [3:0]         done_o,
  output logic [3:0]         irq_o,
  output logic [3:0]         dst_reload_o
);

  localparam int NCH = NUM_CH;

  logic [NCH-1:0] chan_pending;
  logic [NCH-1:0] chan_ready_next;
  logic [NCH-1:0] chan_unit_done;

  assign chan_unit_done = grant_o & {NCH{unit_done_i}};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic special;
    if (i == 1) begin : g_fifo_a
      assign special = fifo_req_i[0];
    end else if (i == 2) begin : g_fifo_b
      assign special = fifo_req_i[1];
    end else begin : g_no_fifo
      assign special = 1'b0;
    end

    dma_trig_chan #(.CH(i), .CW(CW), .START_LAT(START_LAT)) u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_i        (arm_i[i]),
      .vblank_i     (vblank_i),
      .hblank_i     (hblank_i),
      .special_i    (special),
      .mode_i       (mode_i[2*i +: 2]),
      .repeat_i     (repeat_i[i]),
      .irq_en_i     (irq_en_i[i]),
      .dst_ctl_i    (dst_ctl_i[2*i +: 2]),
      .count_i      (count_i[i*CW +: CW]),
      .unit_done_i  (chan_unit_done[i]),
      .en_o         (enable_o[i]),
      .pending_o    (chan_pending[i]),
      .ready_next_o (chan_ready_next[i]),
      .done_o       (done_o[i]),
      .irq_o        (irq_o[i]),
      .reload_o     (dst_reload_o[i])
    );
  end

  dma_grant_arb #(.N(NCH)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready_next_i (chan_ready_next),
    .unit_done_i  (unit_done_i),
    .grant_o      (grant_o)
  );

  assign stall_o = |chan_pending;

endmodule

// File: rtl/dma_trig_sched_chk.sv
module dma_trig_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] arm_i,
  input logic       unit_done_i,
  input logic [3:0] grant_o,
  input logic       stall_o,
  input logic [3:0] enable_o,
  input logic [3:0] done_o,
  input logic [3:0] irq_o,
  input logic [3:0] dst_reload_o,
  input logic [3:0] chan_pending
);

  a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  a_r5_grant_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != 4'd0) |-> ((grant_o & chan_pending) == grant_o));

  a_r6_hold_mid_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != 4'd0 && !unit_done_i) |=> (grant_o == $past(grant_o)));

  a_r9_stall_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != 4'd0) |-> stall_o);

  a_r8_done_after_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o != 4'd0) |-> ($past(unit_done_i) && done_o == $past(grant_o)));

  a_r8_pulses_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~done_o) == 4'd0) && ((dst_reload_o & ~done_o) == 4'd0));

  a_r10_enable_only_by_arm: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((enable_o & ~$past(enable_o) & ~$past(arm_i)) == 4'd0));

endmodule

bind dma_trig_sched dma_trig_sched_chk u_chk (.*);

// File: tb/test_dma_trig_sched.sv
module test_dma_trig_sched;
  localparam int CW  = 3;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [3:0]      arm;
  logic            vbl, hbl;
  logic [1:0]      fifo;
  logic [7:0]      mode_v, dctl_v;
  logic [3:0]      rpt_v, irqen_v;
  logic [4*CW-1:0] cnt_v;
  logic            unit_done;
  logic [3:0]      grant, en, done, irq, rel;
  logic            stall;

  dma_trig_sched #(.CW(CW), .START_LAT(LAT)) i_dma_trig_sched (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .vblank_i(vbl), .hblank_i(hbl),
    .fifo_req_i(fifo), .mode_i(mode_v), .repeat_i(rpt_v), .irq_en_i(irqen_v),
    .dst_ctl_i(dctl_v), .count_i(cnt_v), .unit_done_i(unit_done),
    .grant_o(grant), .stall_o(stall), .enable_o(en), .done_o(done),
    .irq_o(irq), .dst_reload_o(rel));

  int checks = 0, fails = 0;
  int units[4], done_n[4], irq_n[4], rel_n[4];
  int log_ch[64];
  int log_n = 0, hold_err = 0, ph = 0;
  bit slow = 0;
  logic [3:0] prev_g = 4'd0;

  function automatic int idx(input logic [3:0] g);
    for (int i = 0; i < 4; i++) if (g[i]) return i;
    return 0;
  endfunction

  // Engine model: one unit per cycle, or one per three cycles when slow.
  initial unit_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_g != 4'd0 && !unit_done && grant != prev_g) hold_err++;
    prev_g = grant;
    for (int i = 0; i < 4; i++) begin
      done_n[i] += int'(done[i]);
      irq_n[i]  += int'(irq[i]);
      rel_n[i]  += int'(rel[i]);
    end
    if (rst_n && grant != 4'd0) begin
      if (!slow || ph == 2) begin
        unit_done = 1'b1;
        ph = 0;
        units[idx(grant)]++;
        if (log_n < 64) log_ch[log_n] = idx(grant);
        log_n++;
      end else begin
        unit_done = 1'b0;
        ph++;
      end
    end else begin
      unit_done = 1'b0;
      ph = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; arm = '0; vbl = 0; hbl = 0; fifo = '0;
    mode_v = '0; dctl_v = '0; rpt_v = '0; irqen_v = '0; cnt_v = '0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
  endtask

  task automatic clear_counts;
    for (int i = 0; i < 4; i++) begin
      units[i] = 0; done_n[i] = 0; irq_n[i] = 0; rel_n[i] = 0;
    end
    log_n = 0;
  endtask

  task automatic set_ch(input int ch, input logic [1:0] m, input logic r,
                        input logic ie, input logic [1:0] dc, input int c);
    mode_v[2*ch +: 2] = m;
    rpt_v[ch]         = r;
    irqen_v[ch]       = ie;
    dctl_v[2*ch +: 2] = dc;
    cnt_v[ch*CW +: CW] = CW'(c);
  endtask

  task automatic pulse_arm(input logic [3:0] m);
    arm = m;
    tick;
    arm = '0;
  endtask

  task automatic wait_idle;
    for (int k = 0; k < 400; k++) begin
      if (!stall && grant == 4'd0) break;
      tick;
    end
    repeat (2) tick;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_counts();
    do_reset();
    // R10 reset state
    chk("R10 grant after reset", int'(grant), 0);
    chk("R10 stall after reset", int'(stall), 0);
    chk("R10 enable after reset", int'(en), 0);
    chk("R10 done after reset", int'(done | irq | rel), 0);

    // Immediate sweep: every channel, every count
    for (int ch = 0; ch < 4; ch++) begin
      for (int c = 0; c < (1 << CW); c++) begin
        int blk, d0, i0, r0, u0;
        logic [2:0] cb;
        cb  = 3'(c);
        blk = (c == 0) ? (1 << CW) : c;
        d0 = done_n[ch]; i0 = irq_n[ch]; r0 = rel_n[ch]; u0 = units[ch];
        set_ch(ch, 2'd0, cb[0], cb[1], cb[2] ? 2'd3 : 2'd1, c);
        pulse_arm(4'(1 << ch));
        tick;
        tick;
        chk("R1 no grant before latency", int'(grant), 0);
        tick;
        chk("R1 grant at latency", int'(grant), 1 << ch);
        repeat (blk - 1) tick;
        chk("R9 stall while units left", int'(stall), 1);
        tick;
        chk("R9 stall drops after last unit", int'(stall), 0);
        chk("R5 grant idle after block", int'(grant), 0);
        chk("R2 block length", units[ch] - u0, blk);
        chk("R7 immediate clears enable", int'(en[ch]), 0);
        chk("R8 done pulse", done_n[ch] - d0, 1);
        chk("R8 irq pulse", irq_n[ch] - i0, int'(cb[1]));
        chk("R8 reload pulse", rel_n[ch] - r0, int'(cb[2]));
      end
    end

    // Blank triggers
    do_reset(); clear_counts();
    set_ch(1, 2'd2, 1'b1, 1'b1, 2'd0, 2);
    set_ch(2, 2'd1, 1'b1, 1'b0, 2'd0, 3);
    pulse_arm(4'b0110);
    repeat (5) tick;
    chk("R3 no start without strobe", int'(stall), 0);
    chk("R3 blank modes stay armed", int'(en), 4'b0110);
    hbl = 1; tick; hbl = 0;
    tick; tick;
    chk("R3 hblank latency before", int'(grant), 0);
    tick;
    chk("R3 hblank grant ch1", int'(grant), 4'b0010);
    hbl = 1; tick; hbl = 0;
    wait_idle();
    chk("R3 busy channel not retriggered", units[1], 2);
    chk("R3 vblank channel untouched by hblank", units[2], 0);
    chk("R8 irq on ch1 block", irq_n[1], 1);
    chk("R7 repeat keeps enable", int'(en[1]), 1);
    vbl = 1; tick; vbl = 0;
    wait_idle();
    chk("R3 vblank starts ch2", units[2], 3);
    chk("R3 hblank channel untouched by vblank", units[1], 2);
    hbl = 1; tick; hbl = 0;
    wait_idle();
    chk("R7 repeat rearms on next strobe", units[1], 4);
    rpt_v[1] = 1'b0;
    hbl = 1; tick; hbl = 0;
    wait_idle();
    chk("R7 last block without repeat", units[1], 6);
    chk("R7 no repeat clears enable", int'(en[1]), 0);
    hbl = 1; tick; hbl = 0;
    wait_idle();
    chk("R7 disabled channel ignores strobe", units[1], 6);

    // Special request
    do_reset(); clear_counts();
    set_ch(0, 2'd3, 1'b1, 1'b0, 2'd0, 2);
    set_ch(1, 2'd3, 1'b1, 1'b0, 2'd0, 4);
    set_ch(2, 2'd3, 1'b1, 1'b0, 2'd0, 1);
    set_ch(3, 2'd3, 1'b1, 1'b0, 2'd0, 2);
    pulse_arm(4'b1111);
    fifo = 2'b01; tick; fifo = '0;
    wait_idle();
    chk("R4 fifo0 starts ch1", units[1], 4);
    chk("R4 fifo0 leaves ch2", units[2], 0);
    fifo = 2'b10; tick; fifo = '0;
    wait_idle();
    chk("R4 fifo1 starts ch2", units[2], 1);
    chk("R4 fifo1 leaves ch1", units[1], 4);
    fifo = 2'b11; hbl = 1; vbl = 1; tick; fifo = '0; hbl = 0; vbl = 0;
    wait_idle();
    chk("R4 ch0 never starts", units[0], 0);
    chk("R4 ch3 never starts", units[3], 0);

    // Priority and preemption
    do_reset(); clear_counts();
    set_ch(2, 2'd0, 1'b0, 1'b0, 2'd0, 4);
    set_ch(3, 2'd0, 1'b0, 1'b0, 2'd0, 4);
    pulse_arm(4'b1100);
    wait_idle();
    for (int k = 0; k < 8; k++) chk("R5 lower channel first", log_ch[k], (k < 4) ? 2 : 3);
    clear_counts();
    set_ch(3, 2'd0, 1'b0, 1'b0, 2'd0, 6);
    set_ch(0, 2'd0, 1'b0, 1'b0, 2'd0, 2);
    pulse_arm(4'b1000);
    tick;
    pulse_arm(4'b0001);
    wait_idle();
    for (int k = 0; k < 8; k++) chk("R5 preempt between units", log_ch[k], (k == 2 || k == 3) ? 0 : 3);

    // Hold while a unit is in progress
    do_reset(); clear_counts();
    slow = 1;
    set_ch(2, 2'd0, 1'b0, 1'b0, 2'd0, 3);
    set_ch(0, 2'd0, 1'b0, 1'b0, 2'd0, 1);
    pulse_arm(4'b0100);
    repeat (3) tick;
    pulse_arm(4'b0001);
    wait_idle();
    chk("R6 no switch mid-unit", hold_err, 0);
    chk("R6 order 0", log_ch[0], 2);
    chk("R6 order 1", log_ch[1], 2);
    chk("R6 order 2", log_ch[2], 0);
    chk("R6 order 3", log_ch[3], 2);

    // Arm while enabled is ignored
    clear_counts();
    set_ch(1, 2'd0, 1'b0, 1'b0, 2'd0, 5);
    pulse_arm(4'b0010);
    repeat (6) tick;
    set_ch(1, 2'd0, 1'b0, 1'b0, 2'd0, 2);
    pulse_arm(4'b0010);
    wait_idle();
    chk("R10 rearm while enabled ignored", units[1], 5);
    chk("R10 single block end", done_n[1], 1);
    slow = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule